// File: doc/BRIEF.md
# Carry and Sum-of-Products Slice Column

This block is the arithmetic datapath of a column of logic slices. Each slice holds two stacked carry multiplexers, a lower one and an upper one, with an XOR gate beside each that forms a sum bit. It also has a selectable chain entry point and a generate-source selector per stage. A dedicated OR stage merges the slice's carry-out with an incoming sum-of-products value, so that several wide AND terms can be combined into a sum of products across neighbouring columns. Output multiplexers choose what drives the main X and Y results and the two bypass results.

The function tables themselves sit outside this block. Their outputs (F and G), their low input bits, the bypass inputs, the shift-out bits and the wide-combiner outputs arrive as ports. Inside a column the carry ripples combinationally from slice 0 upward. All results are captured in one bank of registers, so every result appears one clock after its inputs. A column of `NUM_SLICES` slices forms a ripple adder 2·`NUM_SLICES` bits wide. Two columns, with the registered sum-of-products output of one feeding the next, form an AND-OR function.

Each slice takes a 16-bit configuration word. The word for slice i occupies bits [16·i+15 : 16·i] of `cfg`.

Top module: `cy_column`

## Requirements
- R1: While `rst` is high at a rising clock edge, every registered output is 0 after that edge. Otherwise every output reflects the inputs present at the previous rising edge (one cycle of latency).
- R2: The chain input of a slice is selected by config bit 0. When the bit is 1, the chain input is the slice's X bypass input. When it is 0, the chain input is the carry-out of the slice below, or `carry_in` for slice 0.
- R3: Each stage has a select value. When the select is 1 the stage passes its chain input; when it is 0 the stage takes its generate source. The select is the table output when the stage's propagate bit is 1, and constant 1 when the bit is 0. The lower stage's propagate bit is config bit 1; it uses F and produces the intermediate carry. The upper stage's propagate bit is config bit 2; it uses G, takes the intermediate carry as its chain input, and produces carry-out.
- R4: Generate source codes (lower stage in config bits 5:3, upper stage in bits 8:6): 0 gives constant 0, 1 gives constant 1, 2 gives table input 1, 3 gives table input 2, 4 gives the bypass input (X for the lower stage, Y for the upper), and 5 gives the AND of table inputs 1 and 2. Codes 6 and 7 give 0.
- R5: The lower sum is F XOR the chain input. The upper sum is G XOR the intermediate carry.
- R6: The sum-of-products output is carry-out OR (`sop_in` AND config bit 9). With bit 9 at 0, the slice starts a chain and `sop_in` has no effect.
- R7: X is selected by config bits 11:10: 0 gives F, 1 gives `f_wide`, 2 gives the lower sum, and 3 gives F.
- R8: Y is selected by config bits 13:12: 0 gives G, 1 gives `g_wide`, 2 gives the upper sum, and 3 gives the sum-of-products output.
- R9: XB is the intermediate carry when config bit 14 is 0, and `f_shift` when it is 1. YB is carry-out when config bit 15 is 0, and `g_shift` when it is 1.
- R10: With F = a XOR b, G = a XOR b of the next bit, generate = a, both propagate bits set and sums routed to X and Y, a column adds two 2·`NUM_SLICES`-bit numbers. The result has slice i's X as bit 2i, its Y as bit 2i+1, and the top slice's carry-out as the final carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| carry_in | input | 1 | Carry into slice 0 |
| f_lut | input | NUM_SLICES | F table output per slice |
| g_lut | input | NUM_SLICES | G table output per slice |
| f_in1 | input | NUM_SLICES | F table input 1 |
| f_in2 | input | NUM_SLICES | F table input 2 |
| g_in1 | input | NUM_SLICES | G table input 1 |
| g_in2 | input | NUM_SLICES | G table input 2 |
| byp_x | input | NUM_SLICES | X bypass input |
| byp_y | input | NUM_SLICES | Y bypass input |
| f_shift | input | NUM_SLICES | F shift-out bit |
| g_shift | input | NUM_SLICES | G shift-out bit |
| f_wide | input | NUM_SLICES | First-stage wide combiner output |
| g_wide | input | NUM_SLICES | Second-stage wide combiner output |
| sop_in | input | NUM_SLICES | Incoming sum-of-products value |
| cfg | input | 16·NUM_SLICES | Static configuration, one word per slice |
| mid_carry_q | output | NUM_SLICES | Intermediate carry |
| carry_out_q | output | NUM_SLICES | Carry-out |
| sum_lo_q | output | NUM_SLICES | Lower sum |
| sum_hi_q | output | NUM_SLICES | Upper sum |
| sop_out_q | output | NUM_SLICES | Outgoing sum-of-products value |
| x_q | output | NUM_SLICES | X result |
| y_q | output | NUM_SLICES | Y result |
| xb_q | output | NUM_SLICES | XB bypass result |
| yb_q | output | NUM_SLICES | YB bypass result |

## Verification
Every result of a column is due exactly one rising edge after its inputs. The bench drives stimulus at a falling edge and compares at the next falling edge, so each comparison sees the single register stage in between. The sum-of-products chain between two columns passes through both register banks. For those vectors the bench holds stimulus for two edges and compares the second column's Y at the second falling edge. Expected sums, carries and AND-OR values are computed arithmetically in the bench from the operands, not from the design.

// File: rtl/cy_pkg.sv
package cy_pkg;

  typedef enum logic [2:0] {
    GEN_ZERO = 3'd0,
    GEN_ONE  = 3'd1,
    GEN_IN1  = 3'd2,
    GEN_IN2  = 3'd3,
    GEN_BYP  = 3'd4,
    GEN_PROD = 3'd5
  } gen_src_e;

  typedef enum logic [1:0] {
    XS_LUT  = 2'd0,
    XS_WIDE = 2'd1,
    XS_SUM  = 2'd2,
    XS_LUT2 = 2'd3
  } xsel_e;

  typedef enum logic [1:0] {
    YS_LUT  = 2'd0,
    YS_WIDE = 2'd1,
    YS_SUM  = 2'd2,
    YS_SOP  = 2'd3
  } ysel_e;

  // Packed MSB first; bit 0 is chain_byp.
  typedef struct packed {
    logic     yb_shift;   // 15
    logic     xb_shift;   // 14
    ysel_e    ysel;       // 13:12
    xsel_e    xsel;       // 11:10
    logic     sop_cont;   // 9
    gen_src_e g_gen;      // 8:6
    gen_src_e f_gen;      // 5:3
    logic     g_prop;     // 2
    logic     f_prop;     // 1
    logic     chain_byp;  // 0
  } slice_cfg_t;

  localparam int CFG_W = $bits(slice_cfg_t);

endpackage

// File: rtl/cy_gen_mux.sv
module cy_gen_mux
  import cy_pkg::*;
(
  input  gen_src_e src,
  input  logic     in1,
  input  logic     in2,
  input  logic     byp,
  output logic     gen
);

  always_comb begin
    case (src)
      GEN_ONE:  gen = 1'b1;
      GEN_IN1:  gen = in1;
      GEN_IN2:  gen = in2;
      GEN_BYP:  gen = byp;
      GEN_PROD: gen = in1 & in2;
      default:  gen = 1'b0;
    endcase
  end

endmodule

// File: rtl/cy_mux_stage.sv
module cy_mux_stage (
  input  logic use_lut,
  input  logic lut,
  input  logic gen,
  input  logic chain_in,
  output logic chain_out,
  output logic sum
);

  logic sel;

  assign sel       = use_lut ? lut : 1'b1;
  assign chain_out = sel ? chain_in : gen;
  assign sum       = lut ^ chain_in;

endmodule

// File: rtl/cy_slice.sv
module cy_slice
  import cy_pkg::*;
(
  input  slice_cfg_t cfg,
  input  logic       f_lut,
  input  logic       g_lut,
  input  logic       f_in1,
  input  logic       f_in2,
  input  logic       g_in1,
  input  logic       g_in2,
  input  logic       byp_x,
  input  logic       byp_y,
  input  logic       chain_from_below,
  input  logic       sop_in,
  input  logic       f_shift,
  input  logic       g_shift,
  input  logic       f_wide,
  input  logic       g_wide,
  output logic       mid_carry,
  output logic       carry_out,
  output logic       sum_lo,
  output logic       sum_hi,
  output logic       sop_out,
  output logic       x_out,
  output logic       y_out,
  output logic       xb_out,
  output logic       yb_out
);

  logic chain_start;
  logic gen_lo;
  logic gen_hi;

  assign chain_start = cfg.chain_byp ? byp_x : chain_from_below;

  cy_gen_mux u_gen_lo (
    .src (cfg.f_gen),
    .in1 (f_in1),
    .in2 (f_in2),
    .byp (byp_x),
    .gen (gen_lo)
  );

  cy_gen_mux u_gen_hi (
    .src (cfg.g_gen),
    .in1 (g_in1),
    .in2 (g_in2),
    .byp (byp_y),
    .gen (gen_hi)
  );

  cy_mux_stage u_stage_lo (
    .use_lut   (cfg.f_prop),
    .lut       (f_lut),
    .gen       (gen_lo),
    .chain_in  (chain_start),
    .chain_out (mid_carry),
    .sum       (sum_lo)
  );

  cy_mux_stage u_stage_hi (
    .use_lut   (cfg.g_prop),
    .lut       (g_lut),
    .gen       (gen_hi),
    .chain_in  (mid_carry),
    .chain_out (carry_out),
    .sum       (sum_hi)
  );

  assign sop_out = carry_out | (cfg.sop_cont & sop_in);

  always_comb begin
    case (cfg.xsel)
      XS_WIDE: x_out = f_wide;
      XS_SUM:  x_out = sum_lo;
      default: x_out = f_lut;
    endcase
  end

  always_comb begin
    case (cfg.ysel)
      YS_WIDE: y_out = g_wide;
      YS_SUM:  y_out = sum_hi;
      YS_SOP:  y_out = sop_out;
      default: y_out = g_lut;
    endcase
  end

  assign xb_out = cfg.xb_shift ? f_shift : mid_carry;
  assign yb_out = cfg.yb_shift ? g_shift : carry_out;

endmodule

// File: rtl/cy_column.sv
module cy_column
  import cy_pkg::*;
#(
  parameter int NUM_SLICES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          carry_in,
  input  logic [NUM_SLICES-1:0]         f_lut,
  input  logic [NUM_SLICES-1:0]         g_lut,
  input  logic [NUM_SLICES-1:0]         f_in1,
  input  logic [NUM_SLICES-1:0]         f_in2,
  input  logic [NUM_SLICES-1:0]         g_in1,
  input  logic [NUM_SLICES-1:0]         g_in2,
  input  logic [NUM_SLICES-1:0]         byp_x,
  input  logic [NUM_SLICES-1:0]         byp_y,
  input  logic [NUM_SLICES-1:0]         f_shift,
  input  logic [NUM_SLICES-1:0]         g_shift,
  input  logic [NUM_SLICES-1:0]         f_wide,
  input  logic [NUM_SLICES-1:0]         g_wide,
  input  logic [NUM_SLICES-1:0]         sop_in,
  input  logic [NUM_SLICES*CFG_W-1:0]   cfg,
  output logic [NUM_SLICES-1:0]         mid_carry_q,
  output logic [NUM_SLICES-1:0]         carry_out_q,
  output logic [NUM_SLICES-1:0]         sum_lo_q,
  output logic [NUM_SLICES-1:0]         sum_hi_q,
  output logic [NUM_SLICES-1:0]         sop_out_q,
  output logic [NUM_SLICES-1:0]         x_q,
  output logic [NUM_SLICES-1:0]         y_q,
  output logic [NUM_SLICES-1:0]         xb_q,
  output logic [NUM_SLICES-1:0]         yb_q
);

  slice_cfg_t              cfg_s   [NUM_SLICES];
  logic [NUM_SLICES-1:0]   below_w;
  logic [NUM_SLICES-1:0]   mid_w, cout_w, slo_w, shi_w, sop_w, x_w, y_w, xb_w, yb_w;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    assign cfg_s[i] = slice_cfg_t'(cfg[i*CFG_W +: CFG_W]);

    if (i == 0) begin : g_bottom
      assign below_w[i] = carry_in;
    end else begin : g_upper
      assign below_w[i] = cout_w[i-1];
    end

    cy_slice u_slice (
      .cfg              (cfg_s[i]),
      .f_lut            (f_lut[i]),
      .g_lut            (g_lut[i]),
      .f_in1            (f_in1[i]),
      .f_in2            (f_in2[i]),
      .g_in1            (g_in1[i]),
      .g_in2            (g_in2[i]),
      .byp_x            (byp_x[i]),
      .byp_y            (byp_y[i]),
      .chain_from_below (below_w[i]),
      .sop_in           (sop_in[i]),
      .f_shift          (f_shift[i]),
      .g_shift          (g_shift[i]),
      .f_wide           (f_wide[i]),
      .g_wide           (g_wide[i]),
      .mid_carry        (mid_w[i]),
      .carry_out        (cout_w[i]),
      .sum_lo           (slo_w[i]),
      .sum_hi           (shi_w[i]),
      .sop_out          (sop_w[i]),
      .x_out            (x_w[i]),
      .y_out            (y_w[i]),
      .xb_out           (xb_w[i]),
      .yb_out           (yb_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_carry_q <= '0;
      carry_out_q <= '0;
      sum_lo_q    <= '0;
      sum_hi_q    <= '0;
      sop_out_q   <= '0;
      x_q         <= '0;
      y_q         <= '0;
      xb_q        <= '0;
      yb_q        <= '0;
    end else begin
      mid_carry_q <= mid_w;
      carry_out_q <= cout_w;
      sum_lo_q    <= slo_w;
      sum_hi_q    <= shi_w;
      sop_out_q   <= sop_w;
      x_q         <= x_w;
      y_q         <= y_w;
      xb_q        <= xb_w;
      yb_q        <= yb_w;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (carry_out_q == '0 && sop_out_q == '0 && x_q == '0 && y_q == '0));

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_chk
    assert_chain_start_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_s[i].chain_byp && !cfg_s[i].f_prop) |=> mid_carry_q[i] == $past(byp_x[i]));

    assert_stage_bypass_R3: assert property (@(posedge clk) disable iff (rst)
      (!cfg_s[i].f_prop && !cfg_s[i].g_prop) |=> carry_out_q[i] == mid_carry_q[i]);

    assert_upper_sum_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> sum_hi_q[i] == ($past(g_lut[i]) ^ mid_carry_q[i]));

    assert_sop_covers_carry_R6: assert property (@(posedge clk) disable iff (rst)
      carry_out_q[i] |-> sop_out_q[i]);

    assert_sop_first_R6: assert property (@(posedge clk) disable iff (rst)
      !cfg_s[i].sop_cont |=> sop_out_q[i] == carry_out_q[i]);

    assert_xb_carry_R9: assert property (@(posedge clk) disable iff (rst)
      !cfg_s[i].xb_shift |=> xb_q[i] == mid_carry_q[i]);

    assert_yb_carry_R9: assert property (@(posedge clk) disable iff (rst)
      !cfg_s[i].yb_shift |=> yb_q[i] == carry_out_q[i]);

    if (i > 0) begin : g_link
      assert_chain_link_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_s[i].chain_byp && !cfg_s[i].f_prop) |=> mid_carry_q[i] == carry_out_q[i-1]);
    end
  end

endmodule

// File: tb/test_cy_column.sv
module test_cy_column;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CW = cy_pkg::CFG_W;
  localparam int AW = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]         carry_in;
  logic [1:0][N-1:0]  f_lut, g_lut, f_in1, f_in2, g_in1, g_in2, byp_x, byp_y;
  logic [1:0][N-1:0]  f_shift, g_shift, f_wide, g_wide;
  logic [N-1:0]       sop_in_l;
  logic [N-1:0]       sop_in_r;
  logic [1:0][N*CW-1:0] cfg;
  logic [1:0][N-1:0]  mid_q, cout_q, slo_q, shi_q, sop_q, x_q, y_q, xb_q, yb_q;

  int n_checks = 0;
  int n_fail   = 0;

  // Horizontal sum-of-products link: left column's top slice feeds the right column's top slice.
  assign sop_in_r = {sop_q[0][N-1], {(N-1){1'b0}}};

  cy_column #(.NUM_SLICES(N)) i_cy_column (
    .clk(clk), .rst(rst), .carry_in(carry_in[0]),
    .f_lut(f_lut[0]), .g_lut(g_lut[0]), .f_in1(f_in1[0]), .f_in2(f_in2[0]),
    .g_in1(g_in1[0]), .g_in2(g_in2[0]), .byp_x(byp_x[0]), .byp_y(byp_y[0]),
    .f_shift(f_shift[0]), .g_shift(g_shift[0]), .f_wide(f_wide[0]), .g_wide(g_wide[0]),
    .sop_in(sop_in_l), .cfg(cfg[0]),
    .mid_carry_q(mid_q[0]), .carry_out_q(cout_q[0]), .sum_lo_q(slo_q[0]), .sum_hi_q(shi_q[0]),
    .sop_out_q(sop_q[0]), .x_q(x_q[0]), .y_q(y_q[0]), .xb_q(xb_q[0]), .yb_q(yb_q[0])
  );

  cy_column #(.NUM_SLICES(N)) i_cy_column_right (
    .clk(clk), .rst(rst), .carry_in(carry_in[1]),
    .f_lut(f_lut[1]), .g_lut(g_lut[1]), .f_in1(f_in1[1]), .f_in2(f_in2[1]),
    .g_in1(g_in1[1]), .g_in2(g_in2[1]), .byp_x(byp_x[1]), .byp_y(byp_y[1]),
    .f_shift(f_shift[1]), .g_shift(g_shift[1]), .f_wide(f_wide[1]), .g_wide(g_wide[1]),
    .sop_in(sop_in_r), .cfg(cfg[1]),
    .mid_carry_q(mid_q[1]), .carry_out_q(cout_q[1]), .sum_lo_q(slo_q[1]), .sum_hi_q(shi_q[1]),
    .sop_out_q(sop_q[1]), .x_q(x_q[1]), .y_q(y_q[1]), .xb_q(xb_q[1]), .yb_q(yb_q[1])
  );

  // Configuration word layout from the requirements (bit 0 first).
  function automatic logic [15:0] mkcfg(input logic cb, input logic fp, input logic gp,
                                        input logic [2:0] fg, input logic [2:0] gg,
                                        input logic sc, input logic [1:0] xs, input logic [1:0] ys,
                                        input logic xbs, input logic ybs);
    return {ybs, xbs, ys, xs, sc, gg, fg, gp, fp, cb};
  endfunction

  function automatic logic gen_val(input int code, input logic i1, input logic i2, input logic b);
    case (code)
      1: return 1'b1;
      2: return i1;
      3: return i2;
      4: return b;
      5: return i1 & i2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    carry_in = '0; f_lut = '0; g_lut = '0; f_in1 = '0; f_in2 = '0; g_in1 = '0; g_in2 = '0;
    byp_x = '0; byp_y = '0; f_shift = '0; g_shift = '0; f_wide = '0; g_wide = '0;
    sop_in_l = '0; cfg = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired got=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: inputs busy during reset, outputs must stay cleared.
    clear_inputs();
    f_lut = '1; g_lut = '1; f_wide = '1; g_wide = '1; carry_in = '1; sop_in_l = '1;
    for (int i = 0; i < N; i++) cfg[0][i*CW +: CW] = mkcfg(0, 0, 0, 1, 1, 1, 1, 3, 1, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset x", 16'(x_q[0]), 16'h0);
    chk("R1 reset y/sop", {8'(y_q[0]), 8'(sop_q[0])}, 16'h0);
    chk("R1 reset carries", {8'(mid_q[0]), 8'(cout_q[0])}, 16'h0);
    rst = 1'b0;
    clear_inputs();
    @(negedge clk);

    // R3 R4 R5 R2: single-slice sweep of generate codes, selects and chain input.
    for (int code = 0; code < 8; code++) begin
      for (int bits = 0; bits < 32; bits++) begin
        for (int pr = 0; pr < 2; pr++) begin
          logic f, i1, i2, b, c, g, gv_lo, gv_hi, mid, co;
          f = bits[0]; i1 = bits[1]; i2 = bits[2]; b = bits[3]; c = bits[4];
          g = bits[1] ^ bits[4];
          clear_inputs();
          f_lut[0][0] = f; g_lut[0][0] = g;
          f_in1[0][0] = i1; f_in2[0][0] = i2; g_in1[0][0] = i1; g_in2[0][0] = i2;
          byp_x[0][0] = b; byp_y[0][0] = ~b; carry_in[0] = c;
          cfg[0][CW-1:0] = mkcfg(0, pr[0], pr[0], code[2:0], code[2:0], 0, 2, 2, 0, 0);
          gv_lo = gen_val(code, i1, i2, b);
          gv_hi = gen_val(code, i1, i2, ~b);
          mid = ((pr == 1) ? f : 1'b1) ? c : gv_lo;
          co  = ((pr == 1) ? g : 1'b1) ? mid : gv_hi;
          @(negedge clk);
          chk("R3 R4 lower stage via xb", 16'(xb_q[0][0]), 16'(mid));
          chk("R3 R4 upper stage via yb", 16'(yb_q[0][0]), 16'(co));
          chk("R5 lower sum via x", 16'(x_q[0][0]), 16'(f ^ c));
          chk("R5 upper sum via y", 16'(y_q[0][0]), 16'(g ^ mid));
        end
      end
    end

    // R7 R8 R9 R6: output multiplexers with both stages passing the chain.
    for (int v = 0; v < 64; v++) begin
      for (int p = 0; p < 16; p++) begin
        logic f, g, fw, gw, fs, gs, si, c, ex, ey, exb, eyb;
        f = p[0]; g = p[1]; fw = p[2]; gw = p[3];
        fs = p[0] ^ p[1]; gs = ~p[2]; si = p[1] ^ p[3]; c = p[2] ^ p[0];
        clear_inputs();
        f_lut[0][0] = f; g_lut[0][0] = g; f_wide[0][0] = fw; g_wide[0][0] = gw;
        f_shift[0][0] = fs; g_shift[0][0] = gs; sop_in_l[0] = si; carry_in[0] = c;
        cfg[0][CW-1:0] = mkcfg(0, 0, 0, 0, 0, 1, v[1:0], v[3:2], v[4], v[5]);
        case (v[1:0]) 2'd1: ex = fw; 2'd2: ex = f ^ c; default: ex = f; endcase
        case (v[3:2]) 2'd1: ey = gw; 2'd2: ey = g ^ c; 2'd3: ey = c | si; default: ey = g; endcase
        exb = v[4] ? fs : c;
        eyb = v[5] ? gs : c;
        @(negedge clk);
        chk("R7 x select", 16'(x_q[0][0]), 16'(ex));
        chk("R8 y select", 16'(y_q[0][0]), 16'(ey));
        chk("R9 xb/yb select", {8'(xb_q[0][0]), 8'(yb_q[0][0])}, {8'(exb), 8'(eyb)});
        chk("R6 sop continue", 16'(sop_q[0][0]), 16'(c | si));
      end
    end

    // R10 R2 R4: ripple adder built from the column, four generate variants.
    for (int mode = 0; mode < 4; mode++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int ci = 0; ci < 2; ci++) begin
            logic [AW-1:0] av, bv;
            logic [AW:0]   exp_s, got_s;
            logic [2:0]    code;
            av = AW'(a); bv = AW'(bi * 17);
            code = (mode == 0) ? 3'd2 : (mode == 1) ? 3'd3 : (mode == 2) ? 3'd4 : 3'd5;
            clear_inputs();
            for (int i = 0; i < N; i++) begin
              f_lut[0][i] = av[2*i] ^ bv[2*i];
              g_lut[0][i] = av[2*i+1] ^ bv[2*i+1];
              f_in1[0][i] = (mode == 0 || mode == 3) ? av[2*i] : ~av[2*i];
              g_in1[0][i] = (mode == 0 || mode == 3) ? av[2*i+1] : ~av[2*i+1];
              f_in2[0][i] = (mode == 1) ? av[2*i] : (mode == 3) ? 1'b1 : ~av[2*i];
              g_in2[0][i] = (mode == 1) ? av[2*i+1] : (mode == 3) ? 1'b1 : ~av[2*i+1];
              byp_x[0][i] = (mode == 2) ? av[2*i] : 1'b1;
              byp_y[0][i] = (mode == 2) ? av[2*i+1] : 1'b1;
              cfg[0][i*CW +: CW] = mkcfg((mode == 0 && i == 0), 1, 1, code, code, 0, 2, 2, 0, 0);
            end
            if (mode == 0) begin
              // Chain starts from the X bypass input; carry_in must be ignored.
              byp_x[0][0] = ci[0];
              carry_in[0] = ~ci[0];
            end else begin
              carry_in[0] = ci[0];
            end
            exp_s = {1'b0, av} + {1'b0, bv} + (AW+1)'(ci);
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
              got_s[2*i]   = x_q[0][i];
              got_s[2*i+1] = y_q[0][i];
            end
            got_s[AW] = cout_q[0][N-1];
            chk((mode == 0) ? "R10 R2 adder, chain from bypass" : "R10 R4 adder", 16'(got_s), 16'(exp_s));
          end
        end
      end
    end

    // R6 R3: wide AND terms across two columns merged by the OR chain.
    for (int sc = 0; sc < 2; sc++) begin
      for (int k = 0; k < 64; k++) begin
        logic [AW-1:0] lt, rt;
        logic          ey;
        lt = k[0] ? '1 : ~(AW'(1) << k[3:1]);
        rt = k[4] ? '1 : ~(AW'(1) << k[2:0]);
        if (k[5]) rt = '0;
        clear_inputs();
        for (int c = 0; c < 2; c++) begin
          for (int i = 0; i < N; i++) begin
            f_lut[c][i] = (c == 0) ? lt[2*i]   : rt[2*i];
            g_lut[c][i] = (c == 0) ? lt[2*i+1] : rt[2*i+1];
            cfg[c][i*CW +: CW] = mkcfg((i == 0), 1, 1, 0, 0,
                                       (c == 1 && i == N-1) ? sc[0] : 1'b0, 0, 3, 0, 0);
          end
          byp_x[c][0] = 1'b1;
        end
        ey = (sc == 1) ? ((&lt) | (&rt)) : (&rt);
        @(negedge clk);
        @(negedge clk);
        chk((sc == 1) ? "R6 AND-OR across columns" : "R6 chain start ignores sop_in",
            16'(y_q[1][N-1]), 16'(ey));
        chk("R3 wide AND left column", 16'(cout_q[0][N-1]), 16'(&lt));
      end
    end

    finish_run();
  end

endmodule